// File: doc/BRIEF.md
# Interrupt Router Register Block with Directed End-of-Interrupt

This block routes 24 interrupt pins to interrupt messages. Software reaches it over a plain 32-bit register bus. A byte offset selects one of three direct registers: an index register, a data window, and an end-of-interrupt (EOI) register. The index register picks an indirect register, and software reads or writes that register through the window. The indirect registers are an identifier, a version word, an arbitration word, a boot configuration word, and a redirection table. The table holds one 64-bit entry per pin, and each entry spans two indirect indices.

Each table entry sets its pin's vector, its trigger mode (edge or level) and its mask. An edge pin records a rising edge until its message is taken. A level pin sends one message and then stays silent while its remote-IRR flag is set. A vector-plus-valid/ready port carries the messages, one at a time, and the lowest-numbered requesting pin goes first. When the directed-EOI mode input is high, the block reports a newer version code and accepts writes to its EOI register. Such a write clears remote-IRR on every level entry that holds the written vector.

Top module: `irq_router`

## Requirements
- R1: Byte offset 0x00 holds an 8-bit index register that reads back in bits 7:0, and offset 0x10 is the data window. Reads of any other offset, except 0x40 as R7 defines, return zero. Writes to them change nothing.
- R2: Index 0x00 holds a 4-bit identifier in bits 27:24, reset value 0, and software can write it. Index 0x02 reads the same identifier and ignores writes. Index 0x03 always reads 0x00000001.
- R3: Index 0x01 reads {8'h00, NUM_PINS-1, 8'h00, ver}. Here ver is 0x11 when eoi_mode_i is 0 and 0x20 when eoi_mode_i is 1, so the word is 0x00170011 or 0x00170020 for 24 pins.
- R4: Index 0x10+2n is the low word of entry n and index 0x11+2n is its high word. Low word: vector in 7:0, remote-IRR in bit 14 (read-only), trigger in bit 15 (1 = level, 0 = edge), mask in bit 16. All other bits are stored. Reset values are 0x00010000 for the low word and 0 for the high word. Indices past the table read zero.
- R5: A rising edge on an edge-mode pin sets a pending flag. This happens even while the entry is masked. The entry requests a message while the flag is set and the entry is unmasked, and acceptance of that message clears the flag.
- R6: A level-mode entry requests a message while its pin is high, the entry is unmasked and remote-IRR is clear. Acceptance of the message sets remote-IRR, and no further message goes out for that pin until remote-IRR clears.
- R7: When eoi_mode_i is 1, a write to offset 0x40 takes bits 7:0 as a vector. It clears remote-IRR on every level entry whose vector equals it and leaves edge entries alone. A level pin that is still high then sends a new message.
- R8: When eoi_mode_i is 0, a write to offset 0x40 has no effect.
- R9: A message stays valid with the same vector until msg_ready_i is seen. Only one message is in flight, and the next one is chosen in the cycle after acceptance, lowest-numbered requesting pin first.
- R10: A masked entry sends no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i and state |
| pin_i | input | 24 | Interrupt pin levels |
| eoi_mode_i | input | 1 | 1 selects the newer version and enables the EOI register |
| msg_valid_o | output | 1 | Interrupt message valid |
| msg_vector_o | output | 8 | Vector of the pending message |
| msg_ready_i | input | 1 | Message accepted when high together with valid |

## Verification
The assertions assume that software does not change an entry's trigger mode while its remote-IRR flag is set. A flag left behind by such a change would be outside what the properties describe. They also assume pins are synchronous to clk_i and that msg_ready_i is a clean level. The stimulus writes each entry's trigger mode once, before it drives that pin. It drives pins, ready and bus signals only on falling edges. Every EOI it issues targets entries that are already programmed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] OFS_EOI    = 8'h40;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_BOOT = 8'h03;
  localparam logic [7:0] IDX_TBL  = 8'h10;

  localparam logic [7:0] VER_LEGACY = 8'h11;
  localparam logic [7:0] VER_DEOI   = 8'h20;

  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;

  localparam logic [31:0] LO_RESET = 32'h0001_0000;
  localparam logic [31:0] LO_RO    = 32'h0000_4000;
endpackage

// File: rtl/irq_rte_table.sv
module irq_rte_table
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [PIN_W-1:0]      wr_sel_i,
  input  logic [31:0]           wdata_i,
  input  logic [PIN_W-1:0]      rd_sel_i,
  output logic [31:0]           rd_lo_o,
  output logic [31:0]           rd_hi_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  eoi_i,
  input  logic [7:0]            eoi_vec_i,
  input  logic                  acc_i,
  input  logic [PIN_W-1:0]      acc_sel_i,
  output logic [NUM_PINS-1:0]   req_o,
  output logic [NUM_PINS*8-1:0] vec_flat_o
);
  logic [31:0]         lo_q [NUM_PINS];
  logic [31:0]         hi_q [NUM_PINS];
  logic [NUM_PINS-1:0] rirr_q, pend_q, pin_q;
  logic [NUM_PINS-1:0] trig, mask, rise;

  assign rise = pin_i & ~pin_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    assign trig[g] = lo_q[g][TRIG_BIT];
    assign mask[g] = lo_q[g][MASK_BIT];
    assign req_o[g] = ~mask[g] & (trig[g] ? (pin_i[g] & ~rirr_q[g]) : pend_q[g]);
    assign vec_flat_o[g*8 +: 8] = lo_q[g][7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        lo_q[i] <= LO_RESET;
        hi_q[i] <= '0;
      end
      rirr_q <= '0;
      pend_q <= '0;
      pin_q  <= '0;
    end else begin
      pin_q <= pin_i;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (wr_lo_i && wr_sel_i == PIN_W'(i)) lo_q[i] <= wdata_i & ~LO_RO;
        if (wr_hi_i && wr_sel_i == PIN_W'(i)) hi_q[i] <= wdata_i;
        // set wins over clear on both flags
        pend_q[i] <= rise[i] |
                     (pend_q[i] & ~(acc_i && acc_sel_i == PIN_W'(i) && !trig[i]));
        rirr_q[i] <= (acc_i && acc_sel_i == PIN_W'(i) && trig[i]) |
                     (rirr_q[i] & ~(eoi_i && trig[i] && lo_q[i][7:0] == eoi_vec_i));
      end
    end
  end

  always_comb begin
    rd_lo_o = lo_q[rd_sel_i];
    rd_lo_o[RIRR_BIT] = rirr_q[rd_sel_i];
    rd_hi_o = hi_q[rd_sel_i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   req_i,
  input  logic [NUM_PINS*8-1:0] vec_flat_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic [7:0]            vector_o,
  output logic [PIN_W-1:0]      pin_o,
  output logic                  acc_o
);
  logic             found;
  logic [PIN_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found = 1'b1;
        pick  = PIN_W'(i);
      end
    end
  end

  assign acc_o = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      vector_o <= '0;
      pin_o    <= '0;
    end else if (!valid_o) begin
      // one idle cycle after acceptance lets table flags settle
      if (found) begin
        valid_o  <= 1'b1;
        pin_o    <= pick;
        vector_o <= vec_flat_i[int'(pick)*8 +: 8];
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int         NUM_PINS  = 24,
  parameter logic [3:0] ID_RESET  = 4'h0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          bus_addr_i,
  input  logic                bus_we_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                eoi_mode_i,
  output logic                msg_valid_o,
  output logic [7:0]          msg_vector_o,
  input  logic                msg_ready_i
);
  localparam int         PIN_W   = $clog2(NUM_PINS);
  localparam logic [7:0] TBL_END = 8'(16 + 2 * NUM_PINS);
  localparam logic [7:0] PIN_MAX = 8'(NUM_PINS - 1);

  logic [7:0]            idx_q;
  logic [3:0]            id_q;
  logic                  win_wr, tbl_hit, eoi_wr, acc;
  logic [7:0]            tbl_off;
  logic [PIN_W-1:0]      tbl_sel, msg_pin;
  logic [31:0]           rd_lo, rd_hi;
  logic [NUM_PINS-1:0]   req;
  logic [NUM_PINS*8-1:0] vec_flat;

  assign win_wr  = bus_we_i && bus_addr_i == OFS_WINDOW;
  assign tbl_hit = idx_q >= IDX_TBL && idx_q < TBL_END;
  assign tbl_off = idx_q - IDX_TBL;
  assign tbl_sel = PIN_W'(tbl_off >> 1);
  assign eoi_wr  = bus_we_i && bus_addr_i == OFS_EOI && eoi_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      id_q  <= ID_RESET;
    end else begin
      if (bus_we_i && bus_addr_i == OFS_INDEX) idx_q <= bus_wdata_i[7:0];
      if (win_wr && idx_q == IDX_ID) id_q <= bus_wdata_i[27:24];
    end
  end

  irq_rte_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (win_wr && tbl_hit && !idx_q[0]),
    .wr_hi_i    (win_wr && tbl_hit && idx_q[0]),
    .wr_sel_i   (tbl_sel),
    .wdata_i    (bus_wdata_i),
    .rd_sel_i   (tbl_sel),
    .rd_lo_o    (rd_lo),
    .rd_hi_o    (rd_hi),
    .pin_i      (pin_i),
    .eoi_i      (eoi_wr),
    .eoi_vec_i  (bus_wdata_i[7:0]),
    .acc_i      (acc),
    .acc_sel_i  (msg_pin),
    .req_o      (req),
    .vec_flat_o (vec_flat)
  );

  irq_arbiter #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .vec_flat_i (vec_flat),
    .ready_i    (msg_ready_i),
    .valid_o    (msg_valid_o),
    .vector_o   (msg_vector_o),
    .pin_o      (msg_pin),
    .acc_o      (acc)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFS_INDEX) begin
      bus_rdata_o = {24'h0, idx_q};
    end else if (bus_addr_i == OFS_WINDOW) begin
      case (idx_q)
        IDX_ID, IDX_ARB: bus_rdata_o = {4'h0, id_q, 24'h0};
        IDX_VER:  bus_rdata_o = {8'h00, PIN_MAX, 8'h00, eoi_mode_i ? VER_DEOI : VER_LEGACY};
        IDX_BOOT: bus_rdata_o = 32'h1;
        default:  if (tbl_hit) bus_rdata_o = idx_q[0] ? rd_hi : rd_lo;
      endcase
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          bus_addr_i,
  input logic                bus_we_i,
  input logic [31:0]         bus_rdata_o,
  input logic                eoi_mode_i,
  input logic                msg_valid_o,
  input logic [7:0]          msg_vector_o,
  input logic                msg_ready_i,
  input logic [7:0]          idx_i,
  input logic [NUM_PINS-1:0] rirr_i,
  input logic [NUM_PINS-1:0] trig_i,
  input logic [PIN_W-1:0]    msg_pin_i
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != 8'h00 && bus_addr_i != 8'h10) |-> bus_rdata_o == 32'h0); // R1

  AST_BOOT_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 8'h10 && idx_i == 8'h03) |-> bus_rdata_o == 32'h1); // R2

  AST_VERSION_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 8'h10 && idx_i == 8'h01) |->
      bus_rdata_o[7:0] == (eoi_mode_i ? 8'h20 : 8'h11)); // R3

  AST_LEVEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |->
      !((($past(rirr_i) & $past(trig_i)) >> msg_pin_i) & NUM_PINS'(1))); // R6

  AST_RIRR_CLEAR_BY_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(rirr_i) & ~rirr_i) != '0) |->
      $past(bus_we_i && bus_addr_i == 8'h40 && eoi_mode_i)); // R7

  AST_EOI_LEGACY_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h40 && !eoi_mode_i) |=>
      (($past(rirr_i) & ~rirr_i) == '0)); // R8

  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> msg_valid_o && $stable(msg_vector_o)); // R9

  AST_MSG_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_ready_i) |=> !msg_valid_o); // R9
endmodule

bind irq_router irq_router_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_rdata_o  (bus_rdata_o),
  .eoi_mode_i   (eoi_mode_i),
  .msg_valid_o  (msg_valid_o),
  .msg_vector_o (msg_vector_o),
  .msg_ready_i  (msg_ready_i),
  .idx_i        (idx_q),
  .rirr_i       (u_tbl.rirr_q),
  .trig_i       (u_tbl.trig),
  .msg_pin_i    (msg_pin)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  localparam int N = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    bus_addr_i = '0;
  logic          bus_we_i = 1'b0;
  logic [31:0]   bus_wdata_i = '0;
  logic [31:0]   bus_rdata_o;
  logic [N-1:0]  pin_i = '0;
  logic          eoi_mode_i = 1'b0;
  logic          msg_valid_o;
  logic [7:0]    msg_vector_o;
  logic          msg_ready_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_router u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_lo [N];
  bit [31:0] m_hi [N];
  bit        m_rirr [N];
  bit        m_pend [N];
  bit        m_pinq [N];
  bit        m_valid;
  bit [7:0]  m_vec;
  int        m_pin;
  bit [7:0]  m_idx;
  bit [3:0]  m_id;

  function automatic bit m_req(int i);
    if (m_lo[i][16]) return 0;
    return m_lo[i][15] ? (pin_i[i] && !m_rirr[i]) : m_pend[i];
  endfunction

  function automatic logic [31:0] m_rd();
    int e;
    if (bus_addr_i == 8'h00) return {24'h0, m_idx};
    if (bus_addr_i != 8'h10) return 32'h0;
    if (m_idx == 8'h00 || m_idx == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_idx == 8'h01) return {8'h00, 8'(N - 1), 8'h00, eoi_mode_i ? 8'h20 : 8'h11};
    if (m_idx == 8'h03) return 32'h1;
    if (m_idx >= 8'h10 && int'(m_idx) < 16 + 2 * N) begin
      e = (int'(m_idx) - 16) / 2;
      return m_idx[0] ? m_hi[e] : (m_lo[e] | (m_rirr[e] ? 32'h4000 : 32'h0));
    end
    return 32'h0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        m_lo[i] = 32'h0001_0000; m_hi[i] = 0;
        m_rirr[i] = 0; m_pend[i] = 0; m_pinq[i] = 0;
      end
      m_valid = 0; m_vec = 0; m_pin = 0; m_idx = 0; m_id = 0;
    end else begin
      bit acc, nv, eoi, win, tbl;
      bit [7:0] nvec;
      int npin, e;
      acc = m_valid && msg_ready_i;
      nv = m_valid; nvec = m_vec; npin = m_pin;
      if (!m_valid) begin
        for (int i = N - 1; i >= 0; i--)
          if (m_req(i)) begin nv = 1; npin = i; nvec = m_lo[i][7:0]; end
      end else if (msg_ready_i) nv = 0;
      eoi = bus_we_i && bus_addr_i == 8'h40 && eoi_mode_i;
      for (int i = 0; i < N; i++) begin
        bit rise, lvl;
        rise = pin_i[i] && !m_pinq[i];
        lvl  = m_lo[i][15];
        m_pend[i] = rise || (m_pend[i] && !(acc && m_pin == i && !lvl));
        m_rirr[i] = (acc && m_pin == i && lvl) ||
                    (m_rirr[i] && !(eoi && lvl && m_lo[i][7:0] == bus_wdata_i[7:0]));
        m_pinq[i] = pin_i[i];
      end
      win = bus_we_i && bus_addr_i == 8'h10;
      tbl = m_idx >= 8'h10 && int'(m_idx) < 16 + 2 * N;
      if (win && m_idx == 8'h00) m_id = bus_wdata_i[27:24];
      if (win && tbl) begin
        e = (int'(m_idx) - 16) / 2;
        if (m_idx[0]) m_hi[e] = bus_wdata_i;
        else m_lo[e] = bus_wdata_i & ~32'h4000;
      end
      if (bus_we_i && bus_addr_i == 8'h00) m_idx = bus_wdata_i[7:0];
      m_valid = nv; m_vec = nvec; m_pin = npin;
    end
    #1;
    if (!done) begin
      chk("R9 msg_valid vs model", {31'h0, msg_valid_o}, {31'h0, m_valid});
      if (m_valid) chk("R9 msg_vector vs model", {24'h0, msg_vector_o}, {24'h0, m_vec});
      chk("R4 rdata vs model", bus_rdata_o, m_rd());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_we_i = 1'b0;
    #1 d = bus_rdata_o;
  endtask

  task automatic rd_ind(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    rd(8'h10, d);
  endtask

  task automatic wait_msg(input string req, input logic [7:0] vec);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk_i);
      #1;
      if (msg_valid_o) break;
    end
    chk(req, {31'h0, msg_valid_o}, 32'h1);
    chk(req, {24'h0, msg_vector_o}, {24'h0, vec});
  endtask

  task automatic no_msg(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      #1 chk(req, {31'h0, msg_valid_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(8'h00, d); chk("R1 index reset", d, 32'h0);
    chk("R9 no message after reset", {31'h0, msg_valid_o}, 32'h0);

    rd_ind(8'h01, d); chk("R3 version legacy", d, 32'h0017_0011);
    @(negedge clk_i); eoi_mode_i = 1'b1;
    rd(8'h10, d); chk("R3 version directed-EOI", d, 32'h0017_0020);
    rd_ind(8'h03, d); chk("R2 boot config", d, 32'h0000_0001);
    rd_ind(8'h00, d); chk("R2 identifier reset", d, 32'h0);
    wr(8'h10, 32'hFA5A_5A5A);
    rd(8'h10, d); chk("R2 identifier write", d, 32'h0A00_0000);
    rd_ind(8'h02, d); chk("R2 arbitration mirrors id", d, 32'h0A00_0000);
    wr(8'h10, 32'h0500_0000);
    rd_ind(8'h00, d); chk("R2 arbitration write ignored", d, 32'h0A00_0000);

    rd(8'h24, d); chk("R1 unmapped offset reads zero", d, 32'h0);
    wr(8'h04, 32'h0000_00FF);
    rd(8'h00, d); chk("R1 unmapped write ignored", d, 32'h0);

    rd_ind(8'h10, d); chk("R4 entry0 low reset", d, 32'h0001_0000);
    rd_ind(8'h40, d); chk("R4 index past table", d, 32'h0);
    wr(8'h00, 8'h14); wr(8'h10, 32'h0000_4031);
    rd(8'h10, d); chk("R4 remote-IRR read-only", d, 32'h0000_0031);
    wr(8'h00, 8'h15); wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, d); chk("R4 high word stored", d, 32'hDEAD_BEEF);
    wr(8'h00, 8'h1A); wr(8'h10, 32'h0000_8031);
    wr(8'h00, 8'h1E); wr(8'h10, 32'h0000_8042);
    wr(8'h00, 8'h22); wr(8'h10, 32'h0001_0050);

    // edge pin 2
    @(negedge clk_i); pin_i[2] = 1'b1;
    wait_msg("R5 edge delivery", 8'h31);
    no_msg("R5 pending cleared on accept", 5);
    @(negedge clk_i); pin_i[2] = 1'b0;

    // level pin 7
    @(negedge clk_i); pin_i[7] = 1'b1;
    wait_msg("R6 level delivery", 8'h42);
    no_msg("R6 blocked by remote-IRR", 5);
    rd_ind(8'h1E, d); chk("R6 remote-IRR set", d, 32'h0000_C042);

    @(negedge clk_i); eoi_mode_i = 1'b0;
    wr(8'h40, 32'h42);
    no_msg("R8 legacy EOI ignored", 3);
    rd_ind(8'h1E, d); chk("R8 remote-IRR kept", d, 32'h0000_C042);

    @(negedge clk_i); eoi_mode_i = 1'b1;
    wr(8'h40, 32'h42);
    wait_msg("R7 redelivery after EOI", 8'h42);
    @(negedge clk_i); pin_i[7] = 1'b0;
    wr(8'h40, 32'h42);
    rd_ind(8'h1E, d); chk("R7 remote-IRR cleared", d, 32'h0000_8042);

    // shared vector: level 5 and edge 2
    @(negedge clk_i); pin_i[5] = 1'b1;
    wait_msg("R6 level pin5", 8'h31);
    @(negedge clk_i); pin_i[5] = 1'b0;
    wr(8'h40, 32'h31);
    no_msg("R7 edge untouched by EOI", 3);
    rd_ind(8'h1A, d); chk("R7 vector match clears", d, 32'h0000_8031);
    rd_ind(8'h14, d); chk("R7 edge entry unchanged", d, 32'h0000_0031);

    // priority and hold
    @(negedge clk_i); msg_ready_i = 1'b0; pin_i[5] = 1'b1; pin_i[7] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      #1 chk("R9 held while not ready", {23'h0, msg_valid_o, msg_vector_o}, 32'h131);
    end
    @(negedge clk_i); msg_ready_i = 1'b1;
    #1 chk("R9 lowest pin first", {23'h0, msg_valid_o, msg_vector_o}, 32'h131);
    wait_msg("R9 next pin after accept", 8'h42);
    @(negedge clk_i); pin_i[5] = 1'b0; pin_i[7] = 1'b0;
    wr(8'h40, 32'h31);
    wr(8'h40, 32'h42);

    // masked edge entry 9
    @(negedge clk_i); pin_i[9] = 1'b1;
    no_msg("R10 masked entry silent", 5);
    wr(8'h00, 8'h22); wr(8'h10, 32'h0000_0050);
    wait_msg("R5 pending kept while masked", 8'h50);
    no_msg("R5 single delivery", 3);

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule